// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address stream for one synchronous DRAM burst. A start strobe captures a starting column together with the burst mode (a length code and an ordering select), and from the next clock the block presents one column address per cycle. It flags the first beat and the final beat of the burst. The ordering is either an upward count or an XOR pattern on the low address bits. In both cases the address stays inside the block of columns that the burst length aligns to.

A full-page length keeps stepping through the whole page, wrapping around it, until a stop or a new start ends it. A start may arrive on any clock. It abandons whatever is left of the current burst and begins a complete new one. A low clock-enable suspends the sequence in place, and the sequence carries on from the same point once clock-enable is high again.

Top module: `burst_col_gen`

## Requirements
- R1: After a synchronous active-low reset, `col_valid`, `col_first` and `col_last` are low.
- R2: A start sampled with `cke` high makes the next cycle present `col_out` equal to the sampled `start_col`, with `col_valid` and `col_first` high. The mode is captured at that start. `len_code` 000 selects 1 beat, 001 selects 2, 010 selects 4, 011 selects 8, and 111 selects full page.
- R3: With `ilv_sel` low and a finite length L, the low log2(L) address bits count upward one per beat and wrap modulo L. For example, length 4 starting at 1 gives 1,2,3,0.
- R4: With `ilv_sel` high and a finite length L, the low log2(L) bits equal the starting low bits XOR the beat index. For example, length 8 starting at 2 gives 2,3,0,1,6,7,4,5.
- R5: For a finite burst, the address bits above the low log2(L) bits equal those of the starting column on every beat.
- R6: `col_last` is high only on the final beat of a finite burst. Unless a new start is taken, `col_valid` is low on the cycle after that beat.
- R7: Code 111 with `ilv_sel` low gives a full-page burst. The address is the starting column plus the beat index, modulo 2^COL_W. `col_last` is never asserted, and the burst continues until a stop or a start.
- R8: Codes 100, 101 and 110, and code 111 with `ilv_sel` high, each give a 1-beat burst.
- R9: A start taken during a burst discards the remaining beats and begins a complete new burst from the new column. A start takes priority over a stop sampled on the same edge.
- R10: While `cke` is low, all outputs hold their values and `start` and `stop` are ignored. The sequence resumes from the same beat when `cke` returns high.
- R11: A stop sampled with `cke` high, and without a start, makes `col_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable; low suspends the sequence |
| start | input | 1 | Begin a new burst at `start_col` |
| start_col | input | COL_W | Starting column of the burst |
| len_code | input | 3 | Burst length code, captured at start |
| ilv_sel | input | 1 | 1 selects XOR ordering, 0 selects upward count |
| stop | input | 1 | End the current burst at once |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_first | output | 1 | Current beat is the first of its burst |
| col_last | output | 1 | Current beat is the final one of a finite burst |

## Verification
The assertions assume that `cke`, `start` and `stop` have a defined level on every sampled edge after reset. They also assume that mode inputs matter only on an edge where a start is taken. The stimulus drives every input away from the clock edge and holds it for a full cycle. It changes `len_code` and `ilv_sel` freely between starts, so the assertions never depend on those inputs staying steady outside a start. Suspend windows are deliberately filled with asserted `start` and `stop` pulses, so that the rule that these pulses are ignored is tested against legal but hostile input.

// File: rtl/burst_col_pkg.sv
// Package: types and length-code constants shared by the burst column sequencer.
// Assumes: at most 8 beats for a finite burst, so the length exponent fits 2 bits.
package burst_col_pkg;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;

    // Burst mode as captured at a start
    typedef struct packed {
        logic [1:0] len_log;  // log2 of the finite length
        logic       full;     // whole-page burst
        logic       ilv;      // XOR ordering
    } burst_mode_t;

endpackage

// File: rtl/burst_mode_decode.sv
// Module: turns the raw length code and ordering select into a burst mode.
// Assumes: reserved codes, and page length combined with XOR ordering,
// fall back to a single beat.
module burst_mode_decode
    import burst_col_pkg::*;
(
    input  logic [2:0]  len_code,
    input  logic        ilv_sel,
    output burst_mode_t mode
);

    // Purpose: map code to exponent / page flag, with the fallback to length 1
    always_comb begin
        mode.len_log = 2'd0;
        mode.full    = 1'b0;
        mode.ilv     = ilv_sel;
        case (len_code)
            LEN_ONE:   mode.len_log = 2'd0;
            LEN_TWO:   mode.len_log = 2'd1;
            LEN_FOUR:  mode.len_log = 2'd2;
            LEN_EIGHT: mode.len_log = 2'd3;
            LEN_PAGE:  mode.full    = !ilv_sel;
            default:   mode.len_log = 2'd0;
        endcase
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
// Module: burst state holder. Captures column and mode on a start, counts
// beats, ends a burst on its last beat or on a stop, and freezes when cke is low.
// Assumes: start outranks stop; beat index wraps at 2^COL_W in page mode.
module burst_seq_ctrl
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  burst_mode_t      mode_in,
    output logic             active,
    output logic             first,
    output logic             is_last,
    output logic [COL_W-1:0] base_col,
    output logic [COL_W-1:0] beat,
    output burst_mode_t      mode_q
);

    localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

    logic [COL_W-1:0] beat_max;

    // Purpose: index of the final beat for the captured finite length
    always_comb beat_max = (ONE << mode_q.len_log) - ONE;

    // Purpose: flag the final beat of a finite burst
    always_comb is_last = active && !mode_q.full && (beat == beat_max);

    // Purpose: burst state update, gated by cke
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            first    <= 1'b0;
            beat     <= '0;
            base_col <= '0;
            mode_q   <= '0;
        end else if (cke) begin
            if (start) begin
                active   <= 1'b1;
                first    <= 1'b1;
                beat     <= '0;
                base_col <= start_col;
                mode_q   <= mode_in;
            end else if (stop) begin
                active <= 1'b0;
                first  <= 1'b0;
            end else if (active) begin
                first <= 1'b0;
                if (is_last) active <= 1'b0;
                else         beat   <= beat + ONE;
            end
        end
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cke && stop && !start |=> !active); // R11

    AST_FIRST_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        first |-> active); // R2

endmodule

// File: rtl/burst_addr_map.sv
// Module: forms the column address from the start column, the beat index and
// the mode. Low bits under the length mask count upward or XOR; bits above stay fixed.
// Assumes: beat stays below the finite length; page mode uses every bit.
module burst_addr_map
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  burst_mode_t      mode,
    output logic [COL_W-1:0] col
);

    localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    // Purpose: select the wrapping field width
    always_comb mask = mode.full ? '1 : ((ONE << mode.len_log) - ONE);

    // Purpose: compute both orderings and keep the bits above the field
    always_comb begin
        low_seq = (base_col + beat) & mask;
        low_ilv = (base_col ^ beat) & mask;
        col     = (base_col & ~mask) | (mode.ilv ? low_ilv : low_seq);
    end

endmodule

// File: rtl/burst_col_gen.sv
// Module: top of the burst column sequencer. Decodes the mode, holds the
// burst state and maps each beat to a column address.
// Assumes: outputs follow the registered state; a start is seen one cycle later.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv_sel,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_first,
    output logic             col_last
);

    burst_mode_t      mode_d;
    burst_mode_t      mode_q;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] beat;

    burst_mode_decode dec_i (
        .len_code (len_code),
        .ilv_sel  (ilv_sel),
        .mode     (mode_d)
    );

    burst_seq_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .mode_in   (mode_d),
        .active    (col_valid),
        .first     (col_first),
        .is_last   (col_last),
        .base_col  (base_col),
        .beat      (beat),
        .mode_q    (mode_q)
    );

    burst_addr_map #(.COL_W(COL_W)) map_i (
        .base_col (base_col),
        .beat     (beat),
        .mode     (mode_q),
        .col      (col_out)
    );

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cke && start |=> col_valid && col_first && col_out == $past(start_col)); // R2

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(col_out) && $stable(col_valid) && $stable(col_last)); // R10

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R6

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.full |-> !col_last); // R7

endmodule

// File: tb/burst_col_gen_tb_top.sv
// Bench: behavioural reference model of the burst sequence, compared every clock.
module burst_col_gen_tb_top;

    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cke = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = 3'b000;
    logic             ilv_sel = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_first;
    logic             col_last;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_act = 0;
    int m_s = 0;
    int m_n = 0;
    int m_len = 1;
    bit m_full = 0;
    bit m_ilv = 0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .len_code(len_code), .ilv_sel(ilv_sel),
        .stop(stop), .col_out(col_out), .col_valid(col_valid),
        .col_first(col_first), .col_last(col_last)
    );

    function automatic int exp_col();
        int base;
        if (m_full) return (m_s + m_n) % 256;
        base = (m_s / m_len) * m_len;
        if (m_ilv) return base + ((m_s % m_len) ^ m_n);
        return base + ((m_s % m_len + m_n) % m_len);
    endfunction

    task automatic model_edge();
        if (!cke) return;
        if (start) begin
            m_act = 1; m_s = int'(start_col); m_n = 0; m_ilv = ilv_sel; m_full = 0;
            case (len_code)
                3'b000: m_len = 1;
                3'b001: m_len = 2;
                3'b010: m_len = 4;
                3'b011: m_len = 8;
                3'b111: begin m_len = 1; m_full = !ilv_sel; end
                default: m_len = 1;
            endcase
        end else if (stop) begin
            m_act = 0;
        end else if (m_act) begin
            if (!m_full && m_n == m_len - 1) m_act = 0;
            else m_n++;
        end
    endtask

    task automatic compare(input string tag);
        bit ok;
        bit e_last;
        e_last = m_act && !m_full && (m_n == m_len - 1);
        checks++;
        ok = (col_valid == m_act);
        if (m_act) ok = ok && (int'(col_out) == exp_col()) &&
                        (col_first == (m_n == 0)) && (col_last == e_last);
        else ok = ok && !col_first && !col_last;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual v=%0b c=%0d f=%0b l=%0b expected v=%0b c=%0d f=%0b l=%0b",
                     tag, col_valid, col_out, col_first, col_last,
                     m_act, m_act ? exp_col() : 0, m_act && m_n == 0, e_last);
        end
    endtask

    // one clock: inputs already set, edge, model, compare at the falling edge
    task automatic step(input bit k, input bit st, input int c, input int code,
                        input bit il, input bit sp, input string tag);
        cke = k; start = st; start_col = COL_W'(c); len_code = 3'(code);
        ilv_sel = il; stop = sp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        // R2 / R3 / R5: length 4 upward from 0x41
        step(1, 1, 8'h41, 2, 0, 0, "R2 start len4");
        idle(5, "R3 R5 seq len4 wrap");
        // R4: length 8 XOR from 0x22
        step(1, 1, 8'h22, 3, 1, 0, "R4 start ilv8");
        idle(9, "R4 R5 ilv len8");
        // length 2 both orders, length 1
        step(1, 1, 8'h17, 1, 0, 0, "R3 len2");
        idle(3, "R6 len2 end");
        step(1, 1, 8'h17, 1, 1, 0, "R4 len2 ilv");
        idle(3, "R6 len2 ilv end");
        step(1, 1, 8'h9d, 0, 0, 0, "R6 len1");
        idle(2, "R6 len1 end");
        // R8: reserved codes and XOR page fall back to one beat
        step(1, 1, 8'h35, 5, 0, 0, "R8 reserved 101");
        idle(2, "R8 reserved end");
        step(1, 1, 8'h36, 4, 1, 0, "R8 reserved 100");
        step(1, 1, 8'h37, 6, 0, 0, "R8 reserved 110");
        step(1, 1, 8'h38, 7, 1, 0, "R8 ilv page");
        idle(2, "R8 ilv page end");
        // R7 / R11: page burst wraps past 255, then stop
        step(1, 1, 8'hfc, 7, 0, 0, "R7 page start");
        idle(262, "R7 page run");
        step(1, 0, 0, 0, 0, 1, "R11 stop page");
        idle(2, "R11 after stop");
        // R9: restart mid-burst, start over stop
        step(1, 1, 8'h80, 3, 0, 0, "R9 first burst");
        idle(3, "R9 run");
        step(1, 1, 8'h0e, 2, 1, 0, "R9 restart");
        idle(2, "R9 new burst");
        step(1, 1, 8'h63, 3, 0, 1, "R9 start beats stop");
        idle(3, "R9 after tie");
        // R10: suspend with noisy start/stop
        step(0, 1, 8'hff, 0, 0, 0, "R10 suspend start");
        step(0, 0, 0, 0, 0, 1, "R10 suspend stop");
        step(0, 1, 8'h11, 7, 0, 1, "R10 suspend both");
        idle(6, "R10 resume");
        step(1, 1, 8'h50, 7, 0, 0, "R10 page start");
        step(0, 0, 0, 0, 0, 1, "R10 page suspend");
        step(1, 0, 0, 0, 0, 0, "R10 page resume");
        // R11: stop inside a finite burst
        step(1, 1, 8'hc4, 3, 1, 0, "R11 burst");
        step(1, 0, 0, 0, 0, 1, "R11 stop finite");
        idle(2, "R11 idle");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1-all: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule